// File: doc/BRIEF.md
# D-Channel Enable and Burst Clock Generator

This block sits between a line-interface device and a layer-2 HDLC controller on a bit-clocked serial link. It counts bit times within each 8 kHz frame, starting from a frame sync, and marks the two D-channel bit times for each direction with an enable strobe. It also produces one gated burst clock for the HDLC transmitter and one for the HDLC receiver.

On the transmit side the block samples the controller's serial data on the rising edges of the transmit burst. It then presents the two captured bits together, with a one-cycle valid strobe. On the receive side it takes a two-bit D-channel word from the line side and drives it out one bit at a time on falling clock edges, so the HDLC receiver can sample it on the burst's rising edges.

The slot positions and the frame length are parameters. If a frame sync is missed, the block goes quiet until the next sync arrives.

Top module: `dchan_burst_gen`

## Requirements
- R1: A high `fsync` at a rising edge of `clk` makes the next clock cycle bit 0 of a frame. A frame is `FRAME_BITS` cycles long, and the next sync is expected while bit `FRAME_BITS-1` is current.
- R2: `den_rx` is high exactly during bits `RX_START` and `RX_START+1` of a synchronised frame, and low at all other times.
- R3: `den_tx` is high exactly during bits `TX_START` and `TX_START+1` of a synchronised frame, which gives one pulse per frame, and low at all other times.
- R4: `rx_bclk` is `clk` gated by an enable that changes only at falling edges of `clk`, so every pulse is a whole high phase of `clk`. A synchronised frame has exactly two rising edges, at the rising clock edges that end bits `RX_START` and `RX_START+1`.
- R5: `tx_bclk` follows the same rule as R4, using the transmit slot.
- R6: `tx_din` is sampled on each rising edge of `tx_bclk`. The first sample goes to `tx_dbits[0]` and the second to `tx_dbits[1]`.
- R7: `tx_dvalid` is high for exactly one cycle, during bit `TX_START+2`, and `tx_dbits` then holds the pair captured in that frame.
- R8: `rx_dout` takes `rx_dbits[0]` at the falling clock edge inside bit `RX_START`, and `rx_dbits[1]` at the falling clock edge inside bit `RX_START+1`, which ends the first `rx_bclk` pulse.
- R9: Outside the receive slot, `rx_dout` holds its last value whatever `rx_dbits` does.
- R10: If `fsync` is low during bit `FRAME_BITS-1`, then no enables, burst edges or valid strobes occur until the next `fsync`. `tx_din` is ignored during that time.
- R11: During reset, `den_rx`, `den_tx`, `tx_dvalid`, `rx_dout`, `tx_dbits` and both burst clocks are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, one cycle high before bit 0 |
| tx_din | input | 1 | Serial D-channel data from the HDLC transmitter |
| rx_dbits | input | 2 | D-channel pair from the line side, bit 0 sent first |
| den_rx | output | 1 | Receive D-channel enable |
| den_tx | output | 1 | Transmit D-channel enable |
| rx_bclk | output | 1 | Receive burst clock for the HDLC receiver |
| tx_bclk | output | 1 | Transmit burst clock for the HDLC transmitter |
| rx_dout | output | 1 | Serial D-channel data to the HDLC receiver |
| tx_dbits | output | 2 | Captured transmit pair, first bit in bit 0 |
| tx_dvalid | output | 1 | One-cycle strobe marking `tx_dbits` as fresh |

## Verification
The assertions assume that `fsync` is a single-cycle pulse, given either while the last bit of a frame is current or while the block is unsynchronised. They also assume the slots lie wholly inside the frame, with at least one bit after each slot.

The stimulus raises sync only at those points. It changes every input one nanosecond after a rising edge. As a result, `rx_dbits` is stable at each falling edge and `tx_din` is stable at each burst rising edge. Unsynchronised frames still drive toggling `tx_din` and new `rx_dbits`, so that R9 and R10 are checked against activity rather than idle inputs.

// File: rtl/dchan_pkg.sv
package dchan_pkg;

  // D-channel bits per frame in each direction
  localparam int SLOT_BITS = 2;

  // true when a bit index lies inside a slot that starts at 'start'
  function automatic bit in_slot(input int idx, input int start);
    return (idx >= start) && (idx < start + SLOT_BITS);
  endfunction

  // position of a bit inside its slot
  function automatic int slot_ofs(input int idx, input int start);
    return idx - start;
  endfunction

endpackage

// File: rtl/dchan_frame_ctr.sv
module dchan_frame_ctr #(
  parameter int FRAME_BITS = 24,
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic [CNT_W-1:0] bit_idx,
  output logic             synced,
  output logic             frame_last
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  assign frame_last = synced && (bit_idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0;
      synced  <= 1'b0;
    end else if (fsync) begin
      bit_idx <= '0;
      synced  <= 1'b1;
    end else if (frame_last) begin
      bit_idx <= '0;
      synced  <= 1'b0;
    end else if (synced) begin
      bit_idx <= bit_idx + 1'b1;
    end
  end

  assert_sync_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (synced && bit_idx == '0));

  assert_sync_lost_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (synced && bit_idx == LAST && !fsync) |=> !synced);

endmodule

// File: rtl/dchan_slot.sv
module dchan_slot #(
  parameter int CNT_W = 5,
  parameter int START = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] bit_idx,
  input  logic             synced,
  output logic             en,
  output logic             gate,
  output logic             bclk
);
  import dchan_pkg::*;

  assign en = synced && in_slot(int'(bit_idx), START);

  // gate moves only while clk is low, so bclk pulses are whole high phases
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate <= 1'b0;
    else        gate <= en;
  end

  assign bclk = clk & gate;

  // R4 for the receive instance, R5 for the transmit instance
  assert_gate_tracks_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gate == en);

endmodule

// File: rtl/dchan_burst_gen.sv
module dchan_burst_gen #(
  parameter int FRAME_BITS = 24,
  parameter int RX_START   = 4,
  parameter int TX_START   = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fsync,
  input  logic                           tx_din,
  input  logic [dchan_pkg::SLOT_BITS-1:0] rx_dbits,
  output logic                           den_rx,
  output logic                           den_tx,
  output logic                           rx_bclk,
  output logic                           tx_bclk,
  output logic                           rx_dout,
  output logic [dchan_pkg::SLOT_BITS-1:0] tx_dbits,
  output logic                           tx_dvalid
);
  import dchan_pkg::*;

  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam int OFS_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
  localparam logic [OFS_W-1:0] OFS_LAST = OFS_W'(SLOT_BITS - 1);

  logic [CNT_W-1:0] bit_idx;
  logic             synced;
  logic             frame_last;
  logic             rx_gate, tx_gate;
  logic [OFS_W-1:0] rx_ofs, tx_ofs;
  logic             tx_capture;
  logic             rx_launch;

  dchan_frame_ctr #(.FRAME_BITS(FRAME_BITS)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .fsync      (fsync),
    .bit_idx    (bit_idx),
    .synced     (synced),
    .frame_last (frame_last)
  );

  dchan_slot #(.CNT_W(CNT_W), .START(RX_START)) u_rx_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_idx (bit_idx),
    .synced  (synced),
    .en      (den_rx),
    .gate    (rx_gate),
    .bclk    (rx_bclk)
  );

  dchan_slot #(.CNT_W(CNT_W), .START(TX_START)) u_tx_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_idx (bit_idx),
    .synced  (synced),
    .en      (den_tx),
    .gate    (tx_gate),
    .bclk    (tx_bclk)
  );

  assign rx_ofs = OFS_W'(slot_ofs(int'(bit_idx), RX_START));
  assign tx_ofs = OFS_W'(slot_ofs(int'(bit_idx), TX_START));

  // a rising clock edge with the gate open is a rising edge of tx_bclk
  assign tx_capture = tx_gate;
  // the falling edge inside each receive enable cycle launches one bit
  assign rx_launch  = den_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_dbits  <= '0;
      tx_dvalid <= 1'b0;
    end else begin
      tx_dvalid <= tx_capture && (tx_ofs == OFS_LAST);
      if (tx_capture) tx_dbits[tx_ofs] <= tx_din;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)         rx_dout <= 1'b0;
    else if (rx_launch) rx_dout <= rx_dbits[rx_ofs];
  end

  assert_rx_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(den_rx) |=> den_rx ##1 !den_rx);

  assert_tx_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(den_tx) |=> den_tx ##1 !den_tx);

  assert_valid_after_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dvalid |-> (!den_tx && $past(den_tx)));

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dvalid |=> !tx_dvalid);

  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !den_rx |-> $stable(rx_dout));

  assert_quiet_unsynced_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!synced && !$past(synced)) |-> (!rx_gate && !tx_gate && !tx_dvalid));

endmodule

// File: tb/dchan_burst_gen_tb.sv
module dchan_burst_gen_tb;

  localparam int F  = 24;
  localparam int RS = 4;
  localparam int TS = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic       tx_din = 1'b0;
  logic [1:0] rx_dbits = 2'b00;
  logic       den_rx, den_tx, rx_bclk, tx_bclk, rx_dout, tx_dvalid;
  logic [1:0] tx_dbits;

  int checks = 0;
  int errors = 0;
  int rx_edges = 0;
  int tx_edges = 0;
  logic exp_rxd = 1'b0;

  always #4 clk = ~clk;

  dchan_burst_gen #(.FRAME_BITS(F), .RX_START(RS), .TX_START(TS)) u_dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .tx_din(tx_din),
    .rx_dbits(rx_dbits), .den_rx(den_rx), .den_tx(den_tx),
    .rx_bclk(rx_bclk), .tx_bclk(tx_bclk), .rx_dout(rx_dout),
    .tx_dbits(tx_dbits), .tx_dvalid(tx_dvalid)
  );

  always @(posedge rx_bclk) rx_edges++;
  always @(posedge tx_bclk) tx_edges++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 den_rx", int'(den_rx), 0);
    chk("R11 den_tx", int'(den_tx), 0);
    chk("R11 tx_dvalid", int'(tx_dvalid), 0);
    chk("R11 rx_dout", int'(rx_dout), 0);
    chk("R11 tx_dbits", int'(tx_dbits), 0);
    chk("R11 bursts", int'(rx_bclk | tx_bclk), 0);
    rst_n = 1'b1;
  endtask

  // raise sync in the current cycle, so the next cycle is bit 0 (R1)
  task automatic sync_pulse();
    @(posedge clk); #1;
    fsync = 1'b1;
  endtask

  task automatic run_frame(input string name, input logic [1:0] txb,
                           input logic [1:0] rxb, input bit live,
                           input bit sync_end);
    int rx0, tx0;
    rx0 = rx_edges;
    tx0 = tx_edges;
    for (int i = 0; i < F; i++) begin
      @(posedge clk); #1;
      fsync = (i == F - 1) ? sync_end : 1'b0;
      if (i == 0) rx_dbits = rxb;
      tx_din = (i >= TS && i < TS + 2) ? txb[i - TS] : logic'(i % 2);
      chk({"R2 den_rx ", name}, int'(den_rx), int'(live && i >= RS && i < RS + 2));
      chk({"R3 den_tx ", name}, int'(den_tx), int'(live && i >= TS && i < TS + 2));
      if (live && i == RS + 1) exp_rxd = rxb[0];
      if (live && i == RS + 2) exp_rxd = rxb[1];
      if (live && (i == RS + 1 || i == RS + 2))
        chk({"R8 rx_dout ", name}, int'(rx_dout), int'(exp_rxd));
      else
        chk({"R9 rx_dout hold ", name}, int'(rx_dout), int'(exp_rxd));
      if (live && i == TS + 2) begin
        chk({"R7 tx_dvalid ", name}, int'(tx_dvalid), 1);
        chk({"R6 tx_dbits ", name}, int'(tx_dbits), int'(txb));
      end else begin
        chk({"R7 tx_dvalid idle ", name}, int'(tx_dvalid), 0);
      end
    end
    chk({"R4 rx_bclk edges ", name}, rx_edges - rx0, live ? 2 : 0);
    chk({"R5 tx_bclk edges ", name}, tx_edges - tx0, live ? 2 : 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    test_reset();
    sync_pulse();                               // R1
    run_frame("A", 2'b01, 2'b10, 1'b1, 1'b1);
    run_frame("B", 2'b10, 2'b01, 1'b1, 1'b1);
    run_frame("C", 2'b11, 2'b00, 1'b1, 1'b1);
    run_frame("D", 2'b00, 2'b11, 1'b1, 1'b0);   // sync missed at end
    run_frame("E R10", 2'b11, 2'b00, 1'b0, 1'b0);
    run_frame("E2 R10", 2'b10, 2'b01, 1'b0, 1'b0);
    chk("R10 tx_dbits untouched", int'(tx_dbits), 0);
    sync_pulse();                               // resync, R1
    run_frame("F", 2'b10, 2'b01, 1'b1, 1'b0);
    summary();
  end

endmodule